// File: doc/BRIEF.md
# Register Control Port with Auto-Increment

This block sits behind the byte-level engine of a two-wire serial slave and turns the received byte stream into register accesses. The engine signals bus start and stop, reports when the device address has matched together with the transfer direction, and hands over each received data byte. The engine also asks for each byte it must send. In a write transfer the first data byte loads a pointer. Bit 7 of that byte is the auto-increment flag and bits 6:0 are the register address. Each later byte is stored at the pointer. A read transfer returns the register at the pointer.

The register file holds a parameterised number of 8-bit registers, each reset to a computed default. One address returns a fixed identification code and one holds sticky event flags, and both are read-only. A mask marks reserved addresses, which keep their defaults. Every register value is presented on a flat output bus so the surrounding logic can use the settings directly.

Top module: `regport_ctl`

## Requirements
- R1: After reset every writable and reserved register at address a holds ((a*29) mod 256) XOR 0x3C, the identification address (1) reads CHIP_ID (0xC5), the status address (15) reads 0, the pointer is 0 with auto-increment off, and wr_ack and rd_valid are low.
- R2: The first byte received after a write-direction address match loads the pointer: bits 6:0 become the register address and bit 7 becomes the auto-increment flag.
- R3: Each later byte of that write transfer is stored in the register at the pointer and appears on cfg_q (address a at bits a*8+7:a*8) one cycle after the byte is presented. With auto-increment on, the pointer then advances by one, wrapping from 127 to 0.
- R4: With auto-increment off, repeated writes and reads in a transfer all target the same register.
- R5: In a read-direction transfer each rd_req yields rd_valid one cycle later, with rd_data equal to the register at the pointer. The pointer keeps the value left by earlier transfers. An rd_req outside a read transfer produces no rd_valid.
- R6: Every byte received in an addressed write transfer, pointer byte included, is acknowledged by wr_ack one cycle later. A byte received while idle or in a read transfer gets no acknowledge and changes nothing.
- R7: Writes to the identification address, the status address, reserved addresses (0 and 8) or addresses 16 and above are acknowledged but leave every register unchanged. Reads from addresses 16 and above return 0.
- R8: Status bit i (of 4) becomes 1 the cycle after evt_in[i] is high and stays 1 until a read of the status address.
- R9: A read of the status address returns the accumulated bits and clears them at the same edge. A bit whose event is high in that same cycle stays set.
- R10: A bus start or stop ends the current transfer, so further bytes are ignored until the next address match. The pointer and the auto-increment flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| bus_stop | input | 1 | Stop seen on the bus |
| adr_hit | input | 1 | Device address matched (one-cycle pulse) |
| adr_read | input | 1 | Direction of the matched transfer, 1 = read |
| wr_valid | input | 1 | Received data byte valid |
| wr_byte | input | 8 | Received data byte |
| wr_ack | output | 1 | Acknowledge for the byte received one cycle earlier |
| rd_req | input | 1 | Engine asks for the next byte to send |
| rd_valid | output | 1 | rd_data holds the requested byte |
| rd_data | output | 8 | Byte to send |
| evt_in | input | 4 | Event pulses for the sticky status bits |
| cfg_q | output | 128 | All register values, address a at bits a*8+7:a*8 |

## Verification
The bench builds the block with its defaults: 16 registers, the identification code at address 1, four status bits at address 15, and reserved addresses 0 and 8. This leaves most of the 7-bit pointer space out of range, so the auto-increment wrap from 127 to 0 can be reached with a two-byte read. The bench also covers writes that land on each kind of protected address, and the case where an event arrives in the same cycle as the status read.

// File: rtl/regport_pkg.sv
package regport_pkg;

  localparam int PTR_W = 7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PTR  = 2'd1,
    PH_DATA = 2'd2,
    PH_READ = 2'd3
  } phase_t;

  // Power-on value of a stored or reserved register at address a.
  function automatic logic [7:0] reg_default(input int unsigned a);
    logic [7:0] mix;
    mix = 8'((a * 29) & 255);
    return mix ^ 8'h3C;
  endfunction

endpackage

// File: rtl/regport_seq.sv
module regport_seq
  import regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             adr_hit,
  input  logic             adr_read,
  input  logic             wr_valid,
  input  logic [7:0]       wr_byte,
  input  logic             rd_req,
  output logic             wr_en,
  output logic             rd_en,
  output logic [PTR_W-1:0] acc_addr,
  output logic             wr_ack
);

  phase_t           phase_q, phase_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             inc_q, inc_d;
  logic             ptr_en, ack_d;

  always_comb begin
    phase_d = phase_q;
    ptr_d   = ptr_q;
    inc_d   = inc_q;
    ptr_en  = 1'b0;
    wr_en   = 1'b0;
    rd_en   = 1'b0;
    ack_d   = 1'b0;
    if (bus_stop || bus_start) begin
      phase_d = PH_IDLE;
    end else if (adr_hit) begin
      phase_d = adr_read ? PH_READ : PH_PTR;
    end else begin
      unique case (phase_q)
        PH_PTR: if (wr_valid) begin
          ptr_d   = wr_byte[PTR_W-1:0];
          inc_d   = wr_byte[7];
          ptr_en  = 1'b1;
          phase_d = PH_DATA;
          ack_d   = 1'b1;
        end
        PH_DATA: if (wr_valid) begin
          wr_en  = 1'b1;
          ack_d  = 1'b1;
          ptr_d  = ptr_q + PTR_W'(1);
          ptr_en = inc_q;
        end
        PH_READ: if (rd_req) begin
          rd_en  = 1'b1;
          ptr_d  = ptr_q + PTR_W'(1);
          ptr_en = inc_q;
        end
        default: ;
      endcase
    end
  end

  assign acc_addr = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_ack  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wr_ack  <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      inc_q <= 1'b0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
      inc_q <= inc_d;
    end
  end

endmodule

// File: rtl/regport_sticky.sv
module regport_sticky #(
  parameter int NSTAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] evt,
  input  logic             clr,
  output logic [NSTAT-1:0] stat
);

  logic [NSTAT-1:0] stat_d;
  logic             stat_en;

  always_comb begin
    stat_d  = clr ? evt : (stat | evt);
    stat_en = clr || (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
    end else if (stat_en) begin
      stat <= stat_d;
    end
  end

endmodule

// File: rtl/regport_regs.sv
module regport_regs
  import regport_pkg::*;
#(
  parameter int                 REG_COUNT = 16,
  parameter int                 ID_ADDR   = 1,
  parameter int                 STAT_ADDR = 15,
  parameter int                 NSTAT     = 4,
  parameter logic [7:0]         CHIP_ID   = 8'hC5,
  parameter logic [REG_COUNT-1:0] RSVD_MASK = 16'h0101
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       addr,
  input  logic [7:0]             wr_data,
  input  logic [NSTAT-1:0]       stat,
  output logic [REG_COUNT*8-1:0] reg_bus,
  output logic [7:0]             rd_data
);

  localparam int BUS_W = REG_COUNT * 8;

  for (genvar a = 0; a < REG_COUNT; a++) begin : g_reg
    if (a == ID_ADDR) begin : g_id
      assign reg_bus[a*8 +: 8] = CHIP_ID;
    end else if (a == STAT_ADDR) begin : g_stat
      assign reg_bus[a*8 +: 8] = 8'(stat);
    end else if (RSVD_MASK[a]) begin : g_rsvd
      assign reg_bus[a*8 +: 8] = reg_default(a);
    end else begin : g_rw
      logic [7:0] val_q;
      logic       hit;
      assign hit = wr_en && (addr == PTR_W'(a));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= reg_default(a);
        end else if (hit) begin
          val_q <= wr_data;
        end
      end
      assign reg_bus[a*8 +: 8] = val_q;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int a = 0; a < REG_COUNT; a++) begin
      if (addr == PTR_W'(a)) rd_data = reg_bus[a*8 +: 8];
    end
  end

  if (BUS_W < 8) begin : g_bad
    initial $error("regport_regs: REG_COUNT must be at least 1");
  end

endmodule

// File: rtl/regport_ctl.sv
module regport_ctl
  import regport_pkg::*;
#(
  parameter int                   REG_COUNT = 16,
  parameter int                   ID_ADDR   = 1,
  parameter int                   STAT_ADDR = 15,
  parameter int                   NSTAT     = 4,
  parameter logic [7:0]           CHIP_ID   = 8'hC5,
  parameter logic [REG_COUNT-1:0] RSVD_MASK = 16'h0101
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_start,
  input  logic                   bus_stop,
  input  logic                   adr_hit,
  input  logic                   adr_read,
  input  logic                   wr_valid,
  input  logic [7:0]             wr_byte,
  output logic                   wr_ack,
  input  logic                   rd_req,
  output logic                   rd_valid,
  output logic [7:0]             rd_data,
  input  logic [NSTAT-1:0]       evt_in,
  output logic [REG_COUNT*8-1:0] cfg_q
);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             wr_en, rd_en, stat_clr;
  logic [PTR_W-1:0] acc_addr;
  logic [NSTAT-1:0] stat;
  logic [7:0]       rd_mux;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  regport_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .adr_hit   (adr_hit),
    .adr_read  (adr_read),
    .wr_valid  (wr_valid),
    .wr_byte   (wr_byte),
    .rd_req    (rd_req),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .acc_addr  (acc_addr),
    .wr_ack    (wr_ack)
  );

  assign stat_clr = rd_en && (acc_addr == PTR_W'(STAT_ADDR));

  regport_sticky #(.NSTAT(NSTAT)) u_sticky (
    .clk   (clk),
    .rst_n (rst_int_n),
    .evt   (evt_in),
    .clr   (stat_clr),
    .stat  (stat)
  );

  regport_regs #(
    .REG_COUNT (REG_COUNT),
    .ID_ADDR   (ID_ADDR),
    .STAT_ADDR (STAT_ADDR),
    .NSTAT     (NSTAT),
    .CHIP_ID   (CHIP_ID),
    .RSVD_MASK (RSVD_MASK)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .addr    (acc_addr),
    .wr_data (wr_byte),
    .stat    (stat),
    .reg_bus (cfg_q),
    .rd_data (rd_mux)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_valid <= 1'b0;
    else            rd_valid <= rd_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rd_data <= 8'h00;
    else if (rd_en)  rd_data <= rd_mux;
  end

endmodule

// File: rtl/regport_ctl_chk.sv
module regport_ctl_chk #(
  parameter int REG_COUNT = 16,
  parameter int STAT_ADDR = 15,
  parameter int NSTAT     = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_valid,
  input logic                   rd_req,
  input logic [NSTAT-1:0]       evt_in,
  input logic                   wr_ack,
  input logic                   rd_valid,
  input logic [REG_COUNT*8-1:0] cfg_q
);

  localparam int W = REG_COUNT * 8;
  localparam logic [W-1:0] KEEP = ~(W'(8'hFF) << (STAT_ADDR * 8));

  logic [NSTAT-1:0] stat_v;
  logic [W-1:0]     cfg_m;
  assign stat_v = cfg_q[STAT_ADDR*8 +: NSTAT];
  assign cfg_m  = cfg_q & KEEP;

  assert_ack_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> $past(wr_valid));

  assert_rdvalid_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));

  assert_cfg_only_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_m != $past(cfg_m)) |-> $past(wr_valid));

  assert_event_captured_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_v & $past(evt_in)) == $past(evt_in)));

  assert_clear_only_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_v) & ~stat_v) != '0) |-> rd_valid);

endmodule

bind regport_ctl regport_ctl_chk #(
  .REG_COUNT (REG_COUNT),
  .STAT_ADDR (STAT_ADDR),
  .NSTAT     (NSTAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .rd_req   (rd_req),
  .evt_in   (evt_in),
  .wr_ack   (wr_ack),
  .rd_valid (rd_valid),
  .cfg_q    (cfg_q)
);

// File: tb/regport_ctl_bench.sv
module regport_ctl_bench;

  localparam int RC = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_start, bus_stop, adr_hit, adr_read;
  logic           wr_valid, rd_req;
  logic [7:0]     wr_byte;
  logic           wr_ack, rd_valid;
  logic [7:0]     rd_data;
  logic [3:0]     evt_in;
  logic [RC*8-1:0] cfg_q;

  always #4 clk = ~clk;

  regport_ctl u_regport_ctl (
    .clk (clk), .rst_n (rst_n), .bus_start (bus_start), .bus_stop (bus_stop),
    .adr_hit (adr_hit), .adr_read (adr_read), .wr_valid (wr_valid),
    .wr_byte (wr_byte), .wr_ack (wr_ack), .rd_req (rd_req),
    .rd_valid (rd_valid), .rd_data (rd_data), .evt_in (evt_in), .cfg_q (cfg_q)
  );

  int    errs = 0;
  int    checks = 0;
  string tag = "R1";

  // Behavioural reference state
  int m_reg[RC];
  int m_stat, m_ptr, m_inc, m_ph;   // phase: 0 idle, 1 pointer, 2 data, 3 read

  function automatic int defv(int a);
    return ((a * 29) % 256) ^ 60;
  endfunction

  function automatic bit writable(int a);
    return a < RC && a != 0 && a != 1 && a != 8 && a != 15;
  endfunction

  function automatic int mread(int a);
    if (a >= RC) return 0;
    if (a == 1) return 'hC5;
    if (a == 15) return m_stat;
    if (a == 0 || a == 8) return defv(a);
    return m_reg[a];
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_cfg();
    for (int a = 0; a < RC; a++)
      chk(int'(cfg_q[a*8 +: 8]) == mread(a), $sformatf("cfg[%0d]", a),
          int'(cfg_q[a*8 +: 8]), mread(a));
  endtask

  task automatic cyc(bit st, bit sp, bit hit, bit rdd, bit wv, int wb, bit rq, int ev);
    int  e_ack = 0;
    int  e_rv  = 0;
    int  e_rd  = 0;
    bit  clr   = 0;
    bus_start = st; bus_stop = sp; adr_hit = hit; adr_read = rdd;
    wr_valid = wv; wr_byte = 8'(wb); rd_req = rq; evt_in = 4'(ev);
    if (sp || st) m_ph = 0;
    else if (hit) m_ph = rdd ? 3 : 1;
    else if (m_ph == 1 && wv) begin
      m_ptr = wb % 128; m_inc = wb / 128; m_ph = 2; e_ack = 1;
    end else if (m_ph == 2 && wv) begin
      e_ack = 1;
      if (writable(m_ptr)) m_reg[m_ptr] = wb;
      if (m_inc != 0) m_ptr = (m_ptr + 1) % 128;
    end else if (m_ph == 3 && rq) begin
      e_rv = 1; e_rd = mread(m_ptr); clr = (m_ptr == 15);
      if (m_inc != 0) m_ptr = (m_ptr + 1) % 128;
    end
    m_stat = clr ? ev : (m_stat | ev);
    @(posedge clk); #1;
    chk(int'(wr_ack) == e_ack, "wr_ack", int'(wr_ack), e_ack);
    chk(int'(rd_valid) == e_rv, "rd_valid", int'(rd_valid), e_rv);
    if (e_rv != 0) chk(int'(rd_data) == e_rd, "rd_data", int'(rd_data), e_rd);
    cmp_cfg();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic hit_w();            cyc(0, 0, 1, 0, 0, 0, 0, 0); endtask
  task automatic hit_r();            cyc(0, 0, 1, 1, 0, 0, 0, 0); endtask
  task automatic send(int b);        cyc(0, 0, 0, 0, 1, b, 0, 0); endtask
  task automatic fetch();            cyc(0, 0, 0, 0, 0, 0, 1, 0); endtask
  task automatic stop();             cyc(0, 1, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_start = 0; bus_stop = 0; adr_hit = 0; adr_read = 0;
    wr_valid = 0; wr_byte = 0; rd_req = 0; evt_in = 0;
    for (int a = 0; a < RC; a++) m_reg[a] = defv(a);
    m_stat = 0; m_ptr = 0; m_inc = 0; m_ph = 0;
    #20;
    tag = "R1 reset";
    cmp_cfg();
    chk(wr_ack == 1'b0, "wr_ack", int'(wr_ack), 0);
    chk(rd_valid == 1'b0, "rd_valid", int'(rd_valid), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(4);
    tag = "R1 pointer at zero"; hit_r(); fetch(); stop();

    tag = "R2 R3 incrementing write";
    hit_w(); send('h82);
    send('h11); send('h22); send('h33); send('h44); send('h55); stop();

    tag = "R5 read continues at pointer";
    hit_r(); fetch(); fetch(); fetch(); stop();
    tag = "R5 pointer then repeated-start read";
    hit_w(); send('h83); hit_r(); fetch(); fetch(); fetch(); stop();

    tag = "R4 fixed address";
    hit_w(); send('h0A); send('hAA); send('hBB); send('hCC); stop();
    hit_r(); fetch(); fetch(); stop();

    tag = "R7 protected writes";
    hit_w(); send('h81); send('h77); send('h99); stop();
    hit_w(); send('h0F); send('hFF); stop();
    hit_w(); send('h08); send('h12); stop();
    hit_w(); send('h64); send('h34); stop();
    hit_r(); fetch(); stop();

    tag = "R6 stray bytes";
    send('h5A); send('h05);
    hit_r(); send('h66); fetch(); stop();
    hit_w(); cyc(0, 0, 0, 0, 0, 0, 1, 0); send('h86); send('h3D); stop();

    tag = "R8 sticky events";
    cyc(0, 0, 0, 0, 0, 0, 0, 1); idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 4); idle(2);
    tag = "R9 read clears, same-cycle event kept";
    hit_w(); send('h0F); hit_r(); cyc(0, 0, 0, 0, 0, 0, 1, 2);
    fetch(); fetch(); stop();

    tag = "R3 wrap 127 to 0";
    hit_w(); send('hFF); hit_r(); fetch(); fetch(); fetch(); stop();

    tag = "R10 start ends transfer";
    hit_w(); send('h85); send('h21);
    cyc(1, 0, 0, 0, 0, 0, 0, 0); send('h42); send('h43);
    hit_r(); fetch(); stop();
    tag = "R10 stop keeps pointer";
    hit_w(); send('h07); stop(); send('h11); hit_r(); fetch(); fetch(); stop();

    idle(3);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule